// File: doc/BRIEF.md
# Batch Serial Word Dumper

This block sends a fixed batch of parallel result words from a design under test out of one serial pin. A host can then capture the words and compare them. Each word becomes one asynchronous frame of ten bit periods: a low start bit, the eight data bits sent least significant first, and a high stop bit. The frames follow one another with no gap. A bit-rate tick from elsewhere in the chip sets the pace. The block moves forward by one bit period only on a clock cycle where that tick is high.

A step counter and a small sequencer schedule the whole batch. From reset they work through the frames of word 0, word 1, and so on up to word N-1. After the last frame the counter keeps counting idle steps until it reaches a fixed limit, and then it parks there. The line stays high whenever no frame is being sent. The words are captured into a snapshot during reset and again when a restart is accepted, so input words that change mid-batch do not disturb the frames. While the block is parked, a restart pulse clears the counter and the whole batch is sent again.

The sequencer has six states:

| State | Meaning | Next state |
|---|---|---|
| ST_ARM | counter at 0, line idle | ST_START on the next enabled step |
| ST_START | start bit | ST_DATA on the next enabled step |
| ST_DATA | data bit | another ST_DATA step for the next bit, or ST_STOP after bit 7 |
| ST_STOP | stop bit | ST_START of the next word, or ST_TAIL after the last word |
| ST_TAIL | counting idle steps below the limit | ST_PARK when the counter reaches the limit |
| ST_PARK | counter held at the limit | ST_ARM on an accepted restart |

From ST_STOP of the last word the sequencer goes straight to ST_PARK if that step already reaches the limit.

Top module: `serial_dump_tx`

## Requirements
- R1: Each word is sent as a frame of 10 enabled steps. Step 0 of the frame is the start bit and drives `tx_line` low. Step 9 is the stop bit and drives it high.
- R2: Frame steps 1 to 8 carry data bits 0 to 7 of the word, in that order, so the least significant bit is sent first.
- R3: The step counter, `tx_line` and `busy` change only on a clock edge where `step_en` is high, or where a restart is accepted.
- R4: Word k is taken from `words_in[8k+7:8k]`. Words are sent in increasing k with no gap between frames: counter values 10k+1 to 10k+10 belong to word k.
- R5: `tx_line` is high at every counter value that is outside a frame. This covers counter value 0, the tail after the last frame, and the whole time the counter holds at its limit.
- R6: After the last frame the counter keeps advancing until it reaches the limit `STEP_LIMIT`, then holds there whatever `step_en` does. Elaboration is rejected unless `STEP_LIMIT` is greater than 10·`NUM_WORDS`.
- R7: During synchronous reset the counter is 0, `tx_line` is high and `busy` is low. The first enabled step after reset is the start bit of word 0.
- R8: A restart pulse is accepted only while the counter holds at its limit. Then the counter returns to 0 with the line high, and the next enabled step is the start bit of word 0. A restart pulse at any other time has no effect.
- R9: The words sent are the values on `words_in` during reset or in the cycle the restart is accepted. Changes to `words_in` during a batch do not affect the frames.
- R10: `busy` goes high with the start bit of word 0. It stays high through the stop bit of the last word and goes low at the next enabled step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Bit-rate tick: one pulse advances the schedule by one step |
| restart | input | 1 | Request to resend the batch; honoured only when parked |
| words_in | input | NUM_WORDS*8 | Packed words, with word k in bits [8k+7:8k] |
| tx_line | output | 1 | Serial output line; high when idle |
| busy | output | 1 | High while frames are being sent |

## Verification
Suppose the sequencer and the step counter lose step with each other, or the word or bit index slips. Within one enabled step the line shows a start bit, data bit or stop bit at a position the host does not expect. Decoding every step of every frame therefore exposes such a fault on the first bad bit. A counter that stops at the wrong value shows up in two ways. `busy` falls on the wrong step. A restart is refused when it should be honoured, or honoured when it should be refused, and the first enabled step after it reveals this as a start bit appearing or missing. A snapshot that follows the inputs live shows up as data bits taken from the words changed mid-batch.

// File: rtl/sdump_pkg.sv
package sdump_pkg;

    // Sequencer states of the serial dumper
    typedef enum logic [2:0] {
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_TAIL,
        ST_PARK
    } sdump_state_e;

endpackage

// File: rtl/sdump_step_ctr.sv
module sdump_step_ctr #(
    parameter int STEP_LIMIT = 50,
    localparam int CW = $clog2(STEP_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step_en,
    output logic [CW-1:0] cnt,
    output logic          at_limit,
    output logic          pre_limit
);

    assign at_limit  = (cnt == CW'(STEP_LIMIT));
    assign pre_limit = (cnt == CW'(STEP_LIMIT - 1));

    // Free-running step count, held once it reaches the limit
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step_en && !at_limit) begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sdump_seq_fsm.sv
module sdump_seq_fsm
    import sdump_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 8,
    localparam int WIW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step_en,
    input  logic           restart_ok,
    input  logic           pre_limit,
    output sdump_state_e   state,
    output logic [WIW-1:0] word_idx,
    output logic [BIW-1:0] bit_idx,
    output logic           drive_low,
    output logic           drive_data,
    output logic           busy,
    output logic           parked
);

    sdump_state_e   state_n;
    logic [WIW-1:0] word_idx_n;
    logic [BIW-1:0] bit_idx_n;
    logic           last_word;
    logic           last_bit;

    assign last_word = (word_idx == WIW'(NUM_WORDS - 1));
    assign last_bit  = (bit_idx == BIW'(WORD_W - 1));

    // Next-state and index logic
    always_comb begin
        state_n    = state;
        word_idx_n = word_idx;
        bit_idx_n  = bit_idx;
        unique case (state)
            ST_ARM: begin
                if (step_en) begin
                    state_n    = ST_START;
                    word_idx_n = '0;
                end
            end
            ST_START: begin
                if (step_en) begin
                    state_n   = ST_DATA;
                    bit_idx_n = '0;
                end
            end
            ST_DATA: begin
                if (step_en) begin
                    if (last_bit) begin
                        state_n = ST_STOP;
                    end else begin
                        bit_idx_n = bit_idx + BIW'(1);
                    end
                end
            end
            ST_STOP: begin
                if (step_en) begin
                    if (!last_word) begin
                        state_n    = ST_START;
                        word_idx_n = word_idx + WIW'(1);
                    end else if (pre_limit) begin
                        state_n = ST_PARK;
                    end else begin
                        state_n = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (step_en && pre_limit) begin
                    state_n = ST_PARK;
                end
            end
            ST_PARK: begin
                if (restart_ok) begin
                    state_n = ST_ARM;
                end
            end
            default: state_n = ST_ARM;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ARM;
            word_idx <= '0;
            bit_idx  <= '0;
        end else begin
            state    <= state_n;
            word_idx <= word_idx_n;
            bit_idx  <= bit_idx_n;
        end
    end

    // Output decode
    always_comb begin
        drive_low  = 1'b0;
        drive_data = 1'b0;
        busy       = 1'b0;
        parked     = 1'b0;
        unique case (state)
            ST_ARM:   ;
            ST_START: begin
                drive_low = 1'b1;
                busy      = 1'b1;
            end
            ST_DATA: begin
                drive_data = 1'b1;
                busy       = 1'b1;
            end
            ST_STOP:  busy   = 1'b1;
            ST_TAIL:  ;
            ST_PARK:  parked = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/sdump_word_bank.sv
module sdump_word_bank #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 8,
    localparam int WIW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic                        clk,
    input  logic                        capture,
    input  logic [NUM_WORDS*WORD_W-1:0] words_in,
    input  logic [WIW-1:0]              word_idx,
    input  logic [BIW-1:0]              bit_idx,
    output logic                        bit_val
);

    logic [WORD_W-1:0] snap [NUM_WORDS];
    logic [WORD_W-1:0] cur_word;

    // One snapshot register per word
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_snap
        always_ff @(posedge clk) begin
            if (capture) begin
                snap[k] <= words_in[k*WORD_W +: WORD_W];
            end
        end
    end

    always_comb begin
        cur_word = '0;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (word_idx == WIW'(k)) begin
                cur_word = snap[k];
            end
        end
    end

    assign bit_val = cur_word[bit_idx];

endmodule

// File: rtl/serial_dump_tx.sv
module serial_dump_tx
    import sdump_pkg::*;
#(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_W     = 8,
    parameter int STEP_LIMIT = 50,
    localparam int FRAME_LEN = WORD_W + 2,
    localparam int CW  = $clog2(STEP_LIMIT + 1),
    localparam int WIW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int BIW = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        step_en,
    input  logic                        restart,
    input  logic [NUM_WORDS*WORD_W-1:0] words_in,
    output logic                        tx_line,
    output logic                        busy
);

    if (STEP_LIMIT <= FRAME_LEN * NUM_WORDS) begin : g_bad_limit
        $error("STEP_LIMIT must exceed the total number of frame steps");
    end

    sdump_state_e   state;
    logic [CW-1:0]  cnt;
    logic           at_limit;
    logic           pre_limit;
    logic [WIW-1:0] word_idx;
    logic [BIW-1:0] bit_idx;
    logic           drive_low;
    logic           drive_data;
    logic           parked;
    logic           restart_ok;
    logic           bit_val;

    assign restart_ok = restart && parked;

    sdump_step_ctr #(
        .STEP_LIMIT(STEP_LIMIT)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .clear    (restart_ok),
        .step_en  (step_en),
        .cnt      (cnt),
        .at_limit (at_limit),
        .pre_limit(pre_limit)
    );

    sdump_seq_fsm #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_W   (WORD_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .restart_ok(restart_ok),
        .pre_limit (pre_limit),
        .state     (state),
        .word_idx  (word_idx),
        .bit_idx   (bit_idx),
        .drive_low (drive_low),
        .drive_data(drive_data),
        .busy      (busy),
        .parked    (parked)
    );

    sdump_word_bank #(
        .NUM_WORDS(NUM_WORDS),
        .WORD_W   (WORD_W)
    ) u_bank (
        .clk     (clk),
        .capture (rst || restart_ok),
        .words_in(words_in),
        .word_idx(word_idx),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    assign tx_line = drive_data ? bit_val : !drive_low;

endmodule

// File: rtl/sdump_checks.sv
module sdump_checks #(
    parameter int NUM_WORDS  = 4,
    parameter int WORD_W     = 8,
    parameter int STEP_LIMIT = 50,
    localparam int CW = $clog2(STEP_LIMIT + 1),
    localparam int END_STEP = (WORD_W + 2) * NUM_WORDS + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          step_en,
    input logic          restart,
    input logic          tx_line,
    input logic          busy,
    input logic [CW-1:0] cnt,
    input logic          at_limit,
    input logic          parked
);

    AST_FROZEN_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !(restart && parked)) |=> ($stable(cnt) && $stable(tx_line) && $stable(busy))); // R3

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_line); // R5

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !tx_line); // R1

    AST_BUSY_END_STEP: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (cnt == CW'(END_STEP))); // R10

    AST_PARK_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        parked |-> at_limit); // R6

    AST_LIMIT_IS_PARK: assert property (@(posedge clk) disable iff (rst)
        at_limit |-> parked); // R6

    AST_RESET_IDLE: assert property (@(posedge clk)
        $fell(rst) |-> (tx_line && !busy && cnt == '0)); // R7

endmodule

bind serial_dump_tx sdump_checks #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .STEP_LIMIT(STEP_LIMIT)
) u_checks (
    .clk     (clk),
    .rst     (rst),
    .step_en (step_en),
    .restart (restart),
    .tx_line (tx_line),
    .busy    (busy),
    .cnt     (cnt),
    .at_limit(at_limit),
    .parked  (parked)
);

// File: tb/serial_dump_tx_test.sv
module serial_dump_tx_test;

    localparam int NW    = 4;
    localparam int LIMIT = 50;
    localparam int FRM   = 10;
    localparam int LAST  = FRM * NW;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            step_en = 1'b0;
    logic            restart = 1'b0;
    logic [NW*8-1:0] words_in;
    logic            tx_line;
    logic            busy;

    int n_cmp = 0;
    int n_bad = 0;
    int s = 0;
    bit done = 1'b0;

    localparam logic [NW*8-1:0] WA = {8'h96, 8'h0F, 8'hC3, 8'h5A};
    localparam logic [NW*8-1:0] WB = {8'h81, 8'h7E, 8'h33, 8'hE4};

    always #5 clk = ~clk;

    serial_dump_tx #(.NUM_WORDS(NW), .WORD_W(8), .STEP_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .step_en(step_en), .restart(restart),
        .words_in(words_in), .tx_line(tx_line), .busy(busy)
    );

    function automatic logic exp_line(int st, logic [NW*8-1:0] w);
        int p, k;
        if (st < 1 || st > LAST) return 1'b1;
        p = (st - 1) % FRM;
        k = (st - 1) / FRM;
        if (p == 0) return 1'b0;
        if (p == FRM - 1) return 1'b1;
        return w[k*8 + p - 1];
    endfunction

    function automatic logic exp_busy(int st);
        return (st >= 1 && st <= LAST);
    endfunction

    function automatic string tag_for(int st);
        int p;
        if (st < 1 || st > LAST) return "R5";
        p = (st - 1) % FRM;
        if (p == 0 || p == FRM - 1) return "R1 R4";
        return "R2 R4";
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s step=%0d actual=%b expected=%b", tag, s, act, exp);
        end
    endtask

    task automatic do_step();
        @(negedge clk) step_en = 1'b1;
        @(negedge clk) step_en = 1'b0;
        if (s < LIMIT) s++;
    endtask

    task automatic pulse_restart();
        @(negedge clk) restart = 1'b1;
        @(negedge clk) restart = 1'b0;
    endtask

    // Checks one step of a batch whose snapshot is w
    task automatic step_and_check(logic [NW*8-1:0] w);
        do_step();
        chk(tag_for(s), tx_line, exp_line(s, w));
        chk("R10 busy", busy, exp_busy(s));
    endtask

    task automatic t_reset();
        words_in = WA;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 line in reset", tx_line, 1'b1);
        chk("R7 busy in reset", busy, 1'b0);
        rst = 1'b0;
        s = 0;
        repeat (5) @(negedge clk);
        chk("R3 no tick line", tx_line, 1'b1);
        chk("R3 no tick busy", busy, 1'b0);
    endtask

    task automatic t_batch_a();
        for (int i = 1; i <= LAST; i++) begin
            if (i == 6) words_in = WB;
            if (i == 17) begin
                pulse_restart();
                chk("R8 ignored restart", tx_line, exp_line(s, WA));
            end
            step_and_check(WA);
            if (i == 1) chk("R7 first step start", tx_line, 1'b0);
            if (i % 7 == 0) begin
                repeat (3) @(negedge clk);
                chk("R3 hold between ticks", tx_line, exp_line(s, WA));
            end
        end
        do_step();
        chk("R10 busy drops", busy, 1'b0);
        chk("R5 tail line", tx_line, 1'b1);
    endtask

    task automatic t_tail_and_limit();
        while (s < LIMIT - 1) begin
            do_step();
            chk("R5 tail line", tx_line, 1'b1);
        end
        pulse_restart();
        do_step();
        chk("R8 restart before limit ignored", tx_line, 1'b1);
        chk("R8 restart before limit busy", busy, 1'b0);
        for (int i = 0; i < 6; i++) begin
            do_step();
            chk("R6 hold at limit", tx_line, 1'b1);
            chk("R6 hold busy", busy, 1'b0);
        end
    endtask

    task automatic t_restart_b();
        words_in = WB;
        pulse_restart();
        s = 0;
        words_in = WA;
        chk("R8 after restart line", tx_line, 1'b1);
        chk("R8 after restart busy", busy, 1'b0);
        for (int i = 1; i <= LAST; i++) begin
            step_and_check(WB);
            if (i == 1) chk("R8 first step start", tx_line, 1'b0);
        end
        do_step();
        chk("R9 batch end busy", busy, 1'b0);
        while (s < LIMIT) do_step();
        words_in = WA;
        pulse_restart();
        s = 0;
        for (int i = 1; i <= FRM; i++) step_and_check(WA);
    endtask

    initial begin
        t_reset();
        t_batch_a();
        t_tail_and_limit();
        t_restart_b();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog step=%0d actual=hung expected=finished", s);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule